// File: doc/BRIEF.md
# Software-Scheduled Static Mesh Router

This block is the router of one tile in a two-dimensional mesh. It moves plain 32-bit words between four neighbour ports and the tile's local processor port. Words carry no header, and the router decodes no addresses. The path of every word comes from a small route table that software writes. Each table entry gives one crossbar setting and the index of the entry that follows it.

The router works through the table one entry at a time. An entry takes effect only in a cycle where every source it names holds a word and every output it drives has room. When it takes effect, every output it drives loads its word in that same cycle, and the pointer jumps to the entry's successor. A short list of entries that loops back on itself therefore replays a fixed communication schedule. Each input has a small FIFO with a ready line. Each output is a register with a valid/ready handshake, so a word moves from an input pin to an output pin in two cycles.

Top module: `static_mesh_router`

## Requirements
- R1: After reset every `in_ready` bit is 1, every `out_valid` bit is 0, the route pointer is at entry 0, and every table entry is cleared to all-none with successor 0.
- R2: Port index 0=north, 1=east, 2=south, 3=west, 4=local. A table entry is `ENTRY_W` bits wide. Bits [3k+2:3k] select the source for output k, where code 0 means none, code p+1 means input p, and codes 6 and 7 mean none. The top `RT_AW` bits hold the successor index. A write happens when `rt_we` is high at a clock edge, and it stores `rt_wdata` at `rt_addr`.
- R3: A word leaves an output with the same 32 bits it had at the selected input, and the words from each input leave in arrival order.
- R4: An entry fires only in a cycle where every selected source FIFO is non-empty and every driven output is empty or being accepted. Otherwise no output loads and no input is popped.
- R5: When an entry fires, the pointer moves to that entry's successor field, so a chain of entries can loop. When an entry does not fire, the pointer stays where it is.
- R6: When one input feeds several outputs in the same entry, all of those outputs receive the same word, and that input is popped exactly once.
- R7: Each input FIFO holds `FIFO_DEPTH` (4) words. `in_ready` is 0 only when the FIFO is full. A word offered while `in_ready` is 0 is not taken, and no accepted word is lost.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output keeps its valid and data unchanged.
- R9: A word accepted at clock edge t reaches the head of its FIFO. If its entry can fire, `out_valid` rises at edge t+1, and not at edge t.
- R10: An entry with all outputs set to none fires every cycle, moves no data, and still advances the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_we | input | 1 | Route table write strobe |
| rt_addr | input | RT_AW | Route table write index |
| rt_wdata | input | ENTRY_W | Route entry to store |
| in_data | input | 5*DATA_W | Input words, port p at bits [32p+31:32p] |
| in_valid | input | 5 | Input word present, one bit per port |
| in_ready | output | 5 | Input FIFO has room, one bit per port |
| out_data | output | 5*DATA_W | Output words, port p at bits [32p+31:32p] |
| out_valid | output | 5 | Output register holds a word |
| out_ready | input | 5 | Downstream takes the output word |

## Verification
The bench first targets partial firing. It supplies only one of the two sources of an entry, and it separately blocks one output of an entry. A router that moved part of a route would let a word through on an output that should have stayed idle. A multicast entry is used to catch a double or early pop, which would show up as a missing or repeated word on one branch. A full input FIFO and a stalled output are held while other traffic waits, to catch dropped words and data that changes while waiting. A 2x2 grid running looping schedules under random backpressure checks that interleaved paths keep their order. A pointer that advanced at the wrong time would reorder the words arriving at a shared sink.

// File: rtl/static_rtr_pkg.sv
package static_rtr_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;
  localparam int PORT_N = 0;
  localparam int PORT_E = 1;
  localparam int PORT_S = 2;
  localparam int PORT_W = 3;
  localparam int PORT_L = 4;
  localparam logic [SEL_W-1:0] SRC_NONE = 3'd0;

  function automatic logic sel_used(input logic [SEL_W-1:0] s);
    return (s != SRC_NONE) && (s <= SEL_W'(NPORT));
  endfunction
endpackage

// File: rtl/static_rtr_fifo.sv
module static_rtr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push;

  assign wr_ready = (cnt_q < CW'(DEPTH));
  assign rd_valid = (cnt_q != '0);
  assign rd_data  = store_q[rp_q];
  assign push     = wr_valid & wr_ready;

  always_comb begin
    wp_d  = push  ? wp_q + 1'b1 : wp_q;
    rp_d  = rd_en ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= wr_data;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_valid); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && !rd_en) |=> (cnt_q == CW'(DEPTH) && !wr_ready)); // R7
endmodule

// File: rtl/static_rtr_seq.sv
module static_rtr_seq
  import static_rtr_pkg::*;
#(
  parameter int ROUTE_DEPTH = 8,
  localparam int AW = $clog2(ROUTE_DEPTH),
  localparam int EW = NPORT * SEL_W + AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rt_we,
  input  logic [AW-1:0]          rt_addr,
  input  logic [EW-1:0]          rt_wdata,
  input  logic [NPORT-1:0]       src_avail,
  input  logic [NPORT-1:0]       dst_room,
  output logic [NPORT*SEL_W-1:0] sel_o,
  output logic [NPORT-1:0]       need_o,
  output logic                   fire_o,
  output logic [NPORT-1:0]       pop_o
);
  logic [EW-1:0] tbl_q [ROUTE_DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;
  logic [EW-1:0] cur;

  always_comb begin
    cur    = tbl_q[ptr_q];
    sel_o  = cur[NPORT*SEL_W-1:0];
    fire_o = 1'b1;
    for (int k = 0; k < NPORT; k++) begin
      logic [SEL_W-1:0] s;
      logic             src_ok;
      s         = cur[k*SEL_W +: SEL_W];
      need_o[k] = sel_used(s);
      src_ok    = 1'b0;
      for (int i = 0; i < NPORT; i++)
        if (s == SEL_W'(i + 1)) src_ok = src_avail[i];
      if (need_o[k] && !(src_ok && dst_room[k])) fire_o = 1'b0;
    end
    pop_o = '0;
    for (int k = 0; k < NPORT; k++)
      for (int i = 0; i < NPORT; i++)
        if (fire_o && need_o[k] && cur[k*SEL_W +: SEL_W] == SEL_W'(i + 1))
          pop_o[i] = 1'b1;
    ptr_d = fire_o ? cur[EW-1 -: AW] : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ROUTE_DEPTH; e++) tbl_q[e] <= '0;
    end else if (rt_we) begin
      tbl_q[rt_addr] <= rt_wdata;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_o && !rt_we) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/static_rtr_xbar.sv
module static_rtr_xbar
  import static_rtr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic [NPORT*SEL_W-1:0] sel,
  input  logic [NPORT-1:0]       need,
  input  logic [NPORT*W-1:0]     head_data,
  input  logic [NPORT-1:0]       out_ready,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*W-1:0]     out_data,
  output logic [NPORT-1:0]       room
);
  logic [NPORT-1:0]   vld_q, vld_d, load;
  logic [NPORT*W-1:0] dat_q, dat_d;

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign room      = ~vld_q | out_ready;

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      logic [W-1:0] pick;
      pick = '0;
      for (int i = 0; i < NPORT; i++)
        if (sel[k*SEL_W +: SEL_W] == SEL_W'(i + 1)) pick = head_data[i*W +: W];
      load[k]          = fire & need[k];
      vld_d[k]         = load[k] | (vld_q[k] & ~out_ready[k]);
      dat_d[k*W +: W]  = load[k] ? pick : dat_q[k*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    dat_q <= dat_d;
  end

  generate
    for (genvar k = 0; k < NPORT; k++) begin : g_chk
      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[k] && !out_ready[k]) |=> (vld_q[k] && $stable(dat_q[k*W +: W]))); // R8
      AST_DST_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        load[k] |-> (!vld_q[k] || out_ready[k])); // R4
      for (genvar j = k + 1; j < NPORT; j++) begin : g_pair
        AST_MCAST_SAME: assert property (@(posedge clk) disable iff (!rst_n)
          (load[k] && load[j] && sel[k*SEL_W +: SEL_W] == sel[j*SEL_W +: SEL_W])
          |=> (dat_q[k*W +: W] == dat_q[j*W +: W])); // R6
      end
    end
  endgenerate
endmodule

// File: rtl/static_mesh_router.sv
module static_mesh_router
  import static_rtr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 4,
  parameter int ROUTE_DEPTH = 8,
  localparam int RT_AW      = $clog2(ROUTE_DEPTH),
  localparam int ENTRY_W    = NPORT * SEL_W + RT_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rt_we,
  input  logic [RT_AW-1:0]        rt_addr,
  input  logic [ENTRY_W-1:0]      rt_wdata,
  input  logic [NPORT*DATA_W-1:0] in_data,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT*DATA_W-1:0] out_data,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready
);
  logic [NPORT-1:0]        head_vld, pop, need, room;
  logic [NPORT*DATA_W-1:0] head_data;
  logic [NPORT*SEL_W-1:0]  sel;
  logic                    fire;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_in
      static_rtr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (in_valid[p]),
        .wr_ready (in_ready[p]),
        .wr_data  (in_data[p*DATA_W +: DATA_W]),
        .rd_en    (pop[p]),
        .rd_valid (head_vld[p]),
        .rd_data  (head_data[p*DATA_W +: DATA_W])
      );
    end
  endgenerate

  static_rtr_seq #(.ROUTE_DEPTH(ROUTE_DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rt_we     (rt_we),
    .rt_addr   (rt_addr),
    .rt_wdata  (rt_wdata),
    .src_avail (head_vld),
    .dst_room  (room),
    .sel_o     (sel),
    .need_o    (need),
    .fire_o    (fire),
    .pop_o     (pop)
  );

  static_rtr_xbar #(.W(DATA_W)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .sel       (sel),
    .need      (need),
    .head_data (head_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .room      (room)
  );

  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pop) <= $countones(need & {NPORT{fire}})); // R6
endmodule

// File: tb/static_mesh_router_tb.sv
`timescale 1ns/1ps
module static_mesh_router_tb_top;
  localparam int DW = 32;
  localparam int NW = 40;

  logic clk, rst_n;
  int   total, bad;
  logic done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // standalone router
  logic         d_we;
  logic [2:0]   d_addr;
  logic [17:0]  d_wdata;
  logic [159:0] d_in_data, d_out_data;
  logic [4:0]   d_in_valid, d_in_ready, d_out_valid, d_out_ready;

  static_mesh_router dut_i (
    .clk(clk), .rst_n(rst_n), .rt_we(d_we), .rt_addr(d_addr), .rt_wdata(d_wdata),
    .in_data(d_in_data), .in_valid(d_in_valid), .in_ready(d_in_ready),
    .out_data(d_out_data), .out_valid(d_out_valid), .out_ready(d_out_ready)
  );

  // 2x2 grid: id 0=(0,0) 1=(0,1) 2=(1,0) 3=(1,1)
  logic         g_we [4];
  logic [2:0]   g_addr [4];
  logic [17:0]  g_wdata [4];
  logic [159:0] g_in_data [4], g_out_data [4];
  logic [4:0]   g_in_valid [4], g_in_ready [4], g_out_valid [4], g_out_ready [4];
  logic [31:0]  loc_in_data [4];
  logic         loc_in_valid [4], loc_out_ready [4];

  generate
    for (genvar r = 0; r < 4; r++) begin : g_grid
      static_mesh_router u_r (
        .clk(clk), .rst_n(rst_n), .rt_we(g_we[r]), .rt_addr(g_addr[r]),
        .rt_wdata(g_wdata[r]), .in_data(g_in_data[r]), .in_valid(g_in_valid[r]),
        .in_ready(g_in_ready[r]), .out_data(g_out_data[r]),
        .out_valid(g_out_valid[r]), .out_ready(g_out_ready[r])
      );
    end
  endgenerate

  function automatic int nbr(input int r, input int p);
    int row, col;
    row = r / 2; col = r % 2;
    case (p)
      0: row = row - 1;
      1: col = col + 1;
      2: row = row + 1;
      default: col = col - 1;
    endcase
    if (row < 0 || row > 1 || col < 0 || col > 1) return -1;
    return row * 2 + col;
  endfunction

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        int nr, op;
        nr = nbr(r, p);
        op = (p + 2) % 4;
        if (nr < 0) begin
          g_in_data[r][p*32 +: 32] = '0;
          g_in_valid[r][p]         = 1'b0;
          g_out_ready[r][p]        = 1'b1;
        end else begin
          g_in_data[r][p*32 +: 32] = g_out_data[nr][op*32 +: 32];
          g_in_valid[r][p]         = g_out_valid[nr][op];
          g_out_ready[r][p]        = g_in_ready[nr][op];
        end
      end
      g_in_data[r][4*32 +: 32] = loc_in_data[r];
      g_in_valid[r][4]         = loc_in_valid[r];
      g_out_ready[r][4]        = loc_out_ready[r];
    end
  end

  // entry: {next[2:0], L, W, S, E, N}; code p+1 selects input p, 0 = none
  function automatic logic [17:0] mk(input int nx, input int sn, input int se,
                                     input int ss, input int sw, input int sl);
    return {3'(nx), 3'(sl), 3'(sw), 3'(ss), 3'(se), 3'(sn)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // logs of accepted output words
  logic [31:0] dlog [5][8];
  int          dcnt [5];
  logic [31:0] a_w [NW], b_w [NW], got11 [2*NW], got00 [NW];
  int          n11, n00;

  always @(negedge clk) begin
    #4;
    for (int p = 0; p < 5; p++)
      if (d_out_valid[p] && d_out_ready[p] && dcnt[p] < 8) begin
        dlog[p][dcnt[p]] = d_out_data[p*32 +: 32];
        dcnt[p]++;
      end
    if (g_out_valid[3][4] && loc_out_ready[3] && n11 < 2*NW) begin
      got11[n11] = g_out_data[3][4*32 +: 32]; n11++;
    end
    if (g_out_valid[0][4] && loc_out_ready[0] && n00 < NW) begin
      got00[n00] = g_out_data[0][4*32 +: 32]; n00++;
    end
  end

  task automatic push(input int p, input logic [31:0] w);
    @(negedge clk);
    d_in_valid[p] = 1'b1;
    d_in_data[p*32 +: 32] = w;
    #1;
    while (!d_in_ready[p]) begin @(negedge clk); #1; end
    @(negedge clk);
    d_in_valid[p] = 1'b0;
  endtask

  task automatic dwr(input int a, input logic [17:0] e);
    @(negedge clk);
    d_we = 1'b1; d_addr = 3'(a); d_wdata = e;
    @(negedge clk);
    d_we = 1'b0;
  endtask

  task automatic gwr(input int r, input int a, input logic [17:0] e);
    @(negedge clk);
    g_we[r] = 1'b1; g_addr[r] = 3'(a); g_wdata[r] = e;
    @(negedge clk);
    g_we[r] = 1'b0;
  endtask

  function automatic logic [31:0] nw(input int i); return 32'h1000_0000 + i; endfunction
  function automatic logic [31:0] sw(input int i); return 32'h2000_0000 + i; endfunction
  function automatic logic [31:0] ww(input int i); return 32'h3000_0000 + i; endfunction
  function automatic logic [31:0] exp11(input int k);
    return (k % 2 == 0) ? a_w[k/2] : b_w[k/2];
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic ok;
    void'($urandom(32'd24681));
    total = 0; bad = 0; done = 1'b0; n11 = 0; n00 = 0;
    for (int p = 0; p < 5; p++) dcnt[p] = 0;
    for (int i = 0; i < NW; i++) begin a_w[i] = $urandom; b_w[i] = $urandom; end
    d_we = 0; d_addr = 0; d_wdata = 0; d_in_data = '0; d_in_valid = '0; d_out_ready = '1;
    for (int r = 0; r < 4; r++) begin
      g_we[r] = 0; g_addr[r] = 0; g_wdata[r] = 0;
      loc_in_data[r] = 0; loc_in_valid[r] = 0; loc_out_ready[r] = 1;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(d_in_ready == 5'h1f && d_out_valid == 5'h00, "R1 reset state",
        {22'd0, d_in_ready, d_out_valid}, {22'd0, 5'h1f, 5'h00});
    rst_n = 1'b1;

    // R7 fill west input, R10 cleared table moves nothing
    for (int i = 0; i < 4; i++) push(3, ww(i));
    repeat (3) @(negedge clk);
    chk(d_in_ready[3] == 1'b0, "R7 full fifo drops ready", 32'(d_in_ready[3]), 32'd0);
    chk(d_out_valid == 5'h00, "R10 none route moves nothing", 32'(d_out_valid), 32'd0);

    // R2 entry1: L<-W next 0 ; entry0: E<-N, S<-N, W<-S next 1
    dwr(1, mk(0, 0, 0, 0, 0, 4));
    dwr(0, mk(1, 0, 1, 1, 3, 0));
    d_out_ready[1] = 1'b0;
    push(0, nw(0));
    repeat (4) @(negedge clk);
    chk(d_out_valid == 5'h00, "R4 missing source blocks entry", 32'(d_out_valid), 32'd0);
    push(2, sw(0));
    chk(d_out_valid[3] == 1'b0, "R9 not before edge t+1", 32'(d_out_valid[3]), 32'd0);
    @(negedge clk);
    chk(d_out_valid[3] && d_out_data[96 +: 32] == sw(0), "R9 R3 west out at t+1",
        d_out_data[96 +: 32], sw(0));
    chk(d_out_valid[1] && d_out_data[32 +: 32] == nw(0), "R3 east data", d_out_data[32 +: 32], nw(0));
    repeat (3) @(negedge clk);
    chk(d_out_valid[1] && d_out_data[32 +: 32] == nw(0), "R8 stalled output holds",
        d_out_data[32 +: 32], nw(0));
    push(0, nw(1));
    push(2, sw(1));
    repeat (4) @(negedge clk);
    chk(dcnt[2] == 1 && dcnt[3] == 1, "R4 full destination blocks entry",
        32'(dcnt[2] * 16 + dcnt[3]), 32'h11);
    chk(dcnt[4] == 1 && d_in_ready[3], "R5 chain reached entry1", 32'(dcnt[4]), 32'd1);
    push(3, ww(4));
    d_out_ready[1] = 1'b1;
    for (int i = 2; i < 5; i++) begin push(0, nw(i)); push(2, sw(i)); end
    repeat (12) @(negedge clk);
    ok = (dcnt[1] == 5 && dcnt[2] == 5);
    for (int i = 0; i < 5; i++) ok &= (dlog[1][i] == nw(i)) && (dlog[2][i] == nw(i));
    chk(ok, "R6 multicast both branches once each", 32'(dcnt[2]), 32'd5);
    ok = (dcnt[3] == 5);
    for (int i = 0; i < 5; i++) ok &= (dlog[3][i] == sw(i));
    chk(ok, "R3 south to west order", 32'(dcnt[3]), 32'd5);
    ok = (dcnt[4] == 5);
    for (int i = 0; i < 5; i++) ok &= (dlog[4][i] == ww(i));
    chk(ok, "R7 R5 no word lost, loop order", 32'(dcnt[4]), 32'd5);
    chk(d_in_ready == 5'h1f, "R7 fifos drained", 32'(d_in_ready), 32'h1f);

    // grid schedules (R2 encoding), then random traffic
    gwr(0, 1, mk(0, 0, 0, 0, 0, 3));
    gwr(0, 0, mk(1, 0, 5, 0, 0, 0));
    gwr(1, 0, mk(0, 0, 0, 4, 0, 0));
    gwr(2, 0, mk(0, 5, 5, 0, 0, 0));
    gwr(3, 1, mk(0, 0, 0, 0, 0, 4));
    gwr(3, 0, mk(1, 0, 0, 0, 0, 1));
    fork
      begin
        int i;
        i = 0;
        while (i < NW) begin
          @(negedge clk);
          loc_in_valid[0] = ($urandom % 4) != 0;
          loc_in_data[0]  = a_w[i];
          #1;
          if (loc_in_valid[0] && g_in_ready[0][4]) i++;
        end
        @(negedge clk); loc_in_valid[0] = 1'b0;
      end
      begin
        int i;
        i = 0;
        while (i < NW) begin
          @(negedge clk);
          loc_in_valid[2] = ($urandom % 3) != 0;
          loc_in_data[2]  = b_w[i];
          #1;
          if (loc_in_valid[2] && g_in_ready[2][4]) i++;
        end
        @(negedge clk); loc_in_valid[2] = 1'b0;
      end
      begin
        while (n11 < 2*NW || n00 < NW) begin
          @(negedge clk);
          loc_out_ready[0] = ($urandom % 3) != 0;
          loc_out_ready[3] = ($urandom % 2) != 0;
        end
      end
    join
    ok = 1'b1;
    for (int k = 0; k < 2*NW; k++) ok &= (got11[k] == exp11(k));
    chk(ok, "R3 R5 grid interleaved sink order", 32'(n11), 32'(2*NW));
    ok = 1'b1;
    for (int k = 0; k < NW; k++) ok &= (got00[k] == b_w[k]);
    chk(ok, "R6 grid multicast branch order", 32'(n00), 32'(NW));
    repeat (5) @(negedge clk);
    chk(g_out_valid[3][4] == 1'b0 && g_out_valid[0][4] == 1'b0, "R3 no extra words",
        32'(g_out_valid[3][4]), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule